// File: doc/BRIEF.md
# Multichannel DAC Serial Register Interface

This block is the digital front end of a multichannel digital-to-analog converter. It is a serial slave (SPI mode 0: data sampled on the rising clock edge, changed on the falling edge, most significant bit first) that receives 24-bit command frames. It keeps three 16-bit registers for every channel: the output code, an offset trim and a gain trim. It also keeps one control word and three 14-bit group offset registers. The system clock oversamples the serial pins through two-flop synchronizers, so the serial clock must stay well below the system clock.

A frame carries a 2-bit command in bits [23:22], a 6-bit address in bits [21:16] and a 16-bit payload in bits [15:0]. Channel n sits at address n + 8. Command 0 reaches the special-function space, which also holds the readback request. A readback is a two-frame exchange. The first frame names the register. The slave returns its value in the low 16 bits of the next frame, after chip select has gone high and then low again. The stored codes, the group offset seen by each channel and a global power-down flag are driven out on parallel ports for the analog side.

A parameter selects a 14-bit code variant. In that variant codes are left-justified in the 16-bit field, so the two low bits are always zero. The analog conversion, the reference supplies and the trim arithmetic are outside this block.

Top module: `spiDacRegs`

## Requirements
- R1: A 24-bit frame with command 3 (bits [23:22]) stores payload bits [15:0] in the data register of channel n, addressed as n + 8 in bits [21:16]. The stored codes appear on `dataCodes` at bits [16n+15:16n].
- R2: Command 2 writes the channel offset register and command 1 writes the channel gain register, at the same channel addresses.
- R3: A channel write to an address below 8, or to an address at or above 8 + NUM_CH, changes no register.
- R4: A command-0 frame to address 5 is a readback request. Payload bits [15:13] give the type and bits [12:7] give the address. The next frame returns the selected value on `miso` in bits [15:0], with bits [23:16] zero. The value is the one held when the request frame ended.
- R5: Readback types 0 and 1 return the channel data register, type 2 the offset register and type 3 the gain register. Type 4 returns a special-function register: address 1 is the control word, addresses 2 to 4 are group offsets 0 to 2 (zero-extended), and every other address reads 0. Types 5 to 7 return 0.
- R6: A readback of types 0 to 3 whose address is not a valid channel returns 0.
- R7: A command-0 write to address 1 stores the control word. Its bit 0 drives `powerDown`, and no other frame changes `powerDown`.
- R8: Command-0 writes to addresses 2, 3 and 4 store payload bits [13:0] in group offsets 0, 1 and 2. Channel n drives on `groupOfs` bits [14n+13:14n] the offset of group n / CH_PER_GROUP, where any group above 2 uses group offset 2.
- R9: After reset, every data, offset, control and group offset register is zero, every gain register is 0xFFFF, `powerDown` is 0, and the first frame returns 0.
- R10: A frame whose bit count is not exactly 24 is discarded. It writes nothing and requests nothing, and the frame that follows it returns 0.
- R11: `miso` is 0 while chip select is high. A frame that follows any frame other than a readback request returns all zeros.
- R12: With CODE_BITS = 14, the two low bits of every stored data, offset and gain value are zero, and the gain registers reset to 0xFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| csN | input | 1 | Active-low chip select; a frame lasts while it is low |
| mosi | input | 1 | Serial data in, most significant bit first |
| miso | output | 1 | Serial readback data out |
| dataCodes | output | NUM_CH*16 | Stored output code of every channel |
| groupOfs | output | NUM_CH*14 | Group offset selected by each channel |
| powerDown | output | 1 | Global power-down flag (control bit 0) |

## Verification
In one cycle, at the end of a frame, the slave both loads the return word of a readback request and runs the write that the same frame may carry. On the next frame it shifts that word out while the new frame's write lands. The bench provokes this collision in every random round. A random write precedes a readback request. The next frame is another random write that often targets the register just read. The bench checks that the returned word is the value the model held before that last write, and that the write is still visible afterwards. A 14-bit instance receives the same serial stream, and its returns are judged against the masked model.

// File: rtl/dacRegPkg.sv
package dacRegPkg;
  localparam int FRAME_BITS = 24;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int GOFS_W     = 14;
  localparam int NUM_GOFS   = 3;
  localparam int CHAN_BASE  = 8;

  localparam logic [1:0] CMD_SPECIAL = 2'd0;
  localparam logic [1:0] CMD_GAIN    = 2'd1;
  localparam logic [1:0] CMD_OFFSET  = 2'd2;
  localparam logic [1:0] CMD_DATA    = 2'd3;

  localparam logic [ADDR_W-1:0] SF_CTRL   = 6'd1;
  localparam logic [ADDR_W-1:0] SF_GOFS0  = 6'd2;
  localparam logic [ADDR_W-1:0] SF_GOFS1  = 6'd3;
  localparam logic [ADDR_W-1:0] SF_GOFS2  = 6'd4;
  localparam logic [ADDR_W-1:0] SF_RDBACK = 6'd5;

  typedef struct packed {
    logic              valid;
    logic [1:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] payload;
  } frameStbT;
endpackage

// File: rtl/spiFrameCtl.sv
module spiFrameCtl
  import dacRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic [WORD_W-1:0] rdValue,
  output frameStbT          stb,
  output logic              miso
);
  localparam int CNT_W = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] sclkSy, csSy, mosiSy;
  logic sclkPrev, csPrev;
  logic sclkRise, sclkFall, csFall, csRise, csIdle;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_BITS-1:0] rxShift, txShift;
  logic isReadback;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSy   <= 2'b00;
      csSy     <= 2'b11;
      mosiSy   <= 2'b00;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkSy   <= {sclkSy[0], sclkIn};
      csSy     <= {csSy[0], csNIn};
      mosiSy   <= {mosiSy[0], mosiIn};
      sclkPrev <= sclkSy[1];
      csPrev   <= csSy[1];
    end
  end

  assign csIdle   = csSy[1];
  assign sclkRise = sclkSy[1] & ~sclkPrev;
  assign sclkFall = ~sclkSy[1] & sclkPrev;
  assign csFall   = ~csSy[1] & csPrev;
  assign csRise   = csSy[1] & ~csPrev;

  always_comb begin
    stb.valid   = csRise && (bitCnt == CNT_W'(FRAME_BITS));
    stb.cmd     = rxShift[23:22];
    stb.addr    = rxShift[21:16];
    stb.payload = rxShift[15:0];
    isReadback  = stb.valid && (stb.cmd == CMD_SPECIAL) && (stb.addr == SF_RDBACK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (csFall) begin
      bitCnt  <= '0;
    end else if (!csIdle && sclkRise) begin
      rxShift <= {rxShift[FRAME_BITS-2:0], mosiSy[1]};
      if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (csRise) begin
      txShift <= isReadback ? {{(FRAME_BITS-WORD_W){1'b0}}, rdValue} : '0;
    end else if (!csIdle && sclkFall) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign miso = csIdle ? 1'b0 : txShift[FRAME_BITS-1];

  // R10: a frame is accepted only with exactly 24 counted bits, at its end
  assert_frame_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.valid |-> (bitCnt == CNT_W'(FRAME_BITS) && csIdle));

  // R10: the bit counter moves only on a serial clock rise or a frame start
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!csFall && !sclkRise) |=> $stable(bitCnt));

  // R11: nothing is driven while chip select is idle
  assert_miso_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (csSy[1] && csPrev) |-> !miso);
endmodule

// File: rtl/dacRegBank.sv
module dacRegBank
  import dacRegPkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int CH_PER_GROUP = 4,
  parameter int CODE_BITS    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  frameStbT                 stb,
  output logic [WORD_W-1:0]        rdValue,
  output logic [NUM_CH*WORD_W-1:0] dataCodes,
  output logic [NUM_CH*GOFS_W-1:0] groupOfs,
  output logic                     powerDown
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [WORD_W-1:0] CODE_MASK = {WORD_W{1'b1}} << (WORD_W - CODE_BITS);

  logic [WORD_W-1:0] dataReg [NUM_CH];
  logic [WORD_W-1:0] ofsReg  [NUM_CH];
  logic [WORD_W-1:0] gainReg [NUM_CH];
  logic [WORD_W-1:0] ctrlReg;
  logic [GOFS_W-1:0] gofsReg [NUM_GOFS];

  logic [ADDR_W-1:0] wrOff, rbOff, rbAddr;
  logic wrHit, rbHit;
  logic [2:0] rbType;
  logic [CH_W-1:0] rbSel;

  always_comb begin
    wrOff  = stb.addr - ADDR_W'(CHAN_BASE);
    wrHit  = (stb.addr >= ADDR_W'(CHAN_BASE)) && (int'(wrOff) < NUM_CH);
    rbType = stb.payload[15:13];
    rbAddr = stb.payload[12:7];
    rbOff  = rbAddr - ADDR_W'(CHAN_BASE);
    rbHit  = (rbAddr >= ADDR_W'(CHAN_BASE)) && (int'(rbOff) < NUM_CH);
    rbSel  = rbOff[CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        dataReg[i] <= '0;
        ofsReg[i]  <= '0;
        gainReg[i] <= CODE_MASK;
      end
    end else if (stb.valid && wrHit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (int'(wrOff) == i) begin
          case (stb.cmd)
            CMD_DATA:   dataReg[i] <= stb.payload & CODE_MASK;
            CMD_OFFSET: ofsReg[i]  <= stb.payload & CODE_MASK;
            CMD_GAIN:   gainReg[i] <= stb.payload & CODE_MASK;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      for (int k = 0; k < NUM_GOFS; k++) gofsReg[k] <= '0;
    end else if (stb.valid && stb.cmd == CMD_SPECIAL) begin
      case (stb.addr)
        SF_CTRL:  ctrlReg    <= stb.payload;
        SF_GOFS0: gofsReg[0] <= stb.payload[GOFS_W-1:0];
        SF_GOFS1: gofsReg[1] <= stb.payload[GOFS_W-1:0];
        SF_GOFS2: gofsReg[2] <= stb.payload[GOFS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdValue = '0;
    case (rbType)
      3'd0, 3'd1: if (rbHit) rdValue = dataReg[rbSel];
      3'd2:       if (rbHit) rdValue = ofsReg[rbSel];
      3'd3:       if (rbHit) rdValue = gainReg[rbSel];
      3'd4: begin
        case (rbAddr)
          SF_CTRL:  rdValue = ctrlReg;
          SF_GOFS0: rdValue = {{(WORD_W-GOFS_W){1'b0}}, gofsReg[0]};
          SF_GOFS1: rdValue = {{(WORD_W-GOFS_W){1'b0}}, gofsReg[1]};
          SF_GOFS2: rdValue = {{(WORD_W-GOFS_W){1'b0}}, gofsReg[2]};
          default:  rdValue = '0;
        endcase
      end
      default: rdValue = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChanOut
    localparam int GRP = g / CH_PER_GROUP;
    localparam int SEL = (GRP >= NUM_GOFS) ? NUM_GOFS - 1 : GRP;
    assign dataCodes[g*WORD_W +: WORD_W] = dataReg[g];
    assign groupOfs[g*GOFS_W +: GOFS_W]  = gofsReg[SEL];
  end

  assign powerDown = ctrlReg[0];

  // R1: a data write to channel 0 lands with the masked payload
  assert_data_store_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && stb.cmd == CMD_DATA && stb.addr == ADDR_W'(CHAN_BASE))
      |=> (dataReg[0] == ($past(stb.payload) & CODE_MASK)));

  // R2: the channel 0 gain register moves only on its own gain write
  assert_gain_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.valid && stb.cmd == CMD_GAIN && stb.addr == ADDR_W'(CHAN_BASE))
      |=> $stable(gainReg[0]));

  // R7: power-down changes only through a control-word write
  assert_pwr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.valid && stb.cmd == CMD_SPECIAL && stb.addr == SF_CTRL)
      |=> $stable(powerDown));

  // R12: stored codes never carry bits below the code width
  assert_code_mask_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((dataReg[0] & ~CODE_MASK) == '0) && ((gainReg[0] & ~CODE_MASK) == '0));
endmodule

// File: rtl/spiDacRegs.sv
module spiDacRegs
  import dacRegPkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int CH_PER_GROUP = 4,
  parameter int CODE_BITS    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclk,
  input  logic                     csN,
  input  logic                     mosi,
  output logic                     miso,
  output logic [NUM_CH*16-1:0]     dataCodes,
  output logic [NUM_CH*14-1:0]     groupOfs,
  output logic                     powerDown
);
  frameStbT stb;
  logic [WORD_W-1:0] rdValue;

  spiFrameCtl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclk),
    .csNIn   (csN),
    .mosiIn  (mosi),
    .rdValue (rdValue),
    .stb     (stb),
    .miso    (miso)
  );

  dacRegBank #(
    .NUM_CH       (NUM_CH),
    .CH_PER_GROUP (CH_PER_GROUP),
    .CODE_BITS    (CODE_BITS)
  ) uBank (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdValue   (rdValue),
    .dataCodes (dataCodes),
    .groupOfs  (groupOfs),
    .powerDown (powerDown)
  );
endmodule

// File: tb/tb_spiDacRegs.sv
module tb_spiDacRegs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, miso14, pd, pd14;
  logic [NCH*16-1:0] codes, codes14;
  logic [NCH*14-1:0] gofs, gofs14;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] mData [NCH];
  logic [15:0] mOfs  [NCH];
  logic [15:0] mGain [NCH];
  logic [15:0] mCtrl;
  logic [13:0] mGofs [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  spiDacRegs #(.NUM_CH(NCH), .CH_PER_GROUP(4), .CODE_BITS(16)) dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .dataCodes(codes), .groupOfs(gofs), .powerDown(pd));

  spiDacRegs #(.NUM_CH(NCH), .CH_PER_GROUP(4), .CODE_BITS(14)) dut14 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso14),
    .dataCodes(codes14), .groupOfs(gofs14), .powerDown(pd14));

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [1:0] c, input logic [5:0] a, input logic [15:0] d);
    return {c, a, d};
  endfunction

  function automatic logic [23:0] rbReq(input logic [2:0] t, input logic [5:0] a);
    return mk(2'd0, 6'd5, {t, a, 7'd0});
  endfunction

  function automatic logic [15:0] expRead(input logic [2:0] t, input logic [5:0] a, input bit narrow);
    logic [15:0] v;
    int ch;
    v = '0;
    ch = int'(a) - 8;
    if (t <= 3'd3) begin
      if (a >= 6'd8 && ch < NCH) begin
        case (t)
          3'd0, 3'd1: v = mData[ch];
          3'd2:       v = mOfs[ch];
          default:    v = mGain[ch];
        endcase
      end
      if (narrow) v = v & 16'hFFFC;
    end else if (t == 3'd4) begin
      if (a == 6'd1) v = mCtrl;
      else if (a >= 6'd2 && a <= 6'd4) v = {2'b00, mGofs[int'(a) - 2]};
    end
    return v;
  endfunction

  function automatic void applyModel(input logic [23:0] f);
    int ch;
    ch = int'(f[21:16]) - 8;
    if (f[23:22] != 2'd0) begin
      if (f[21:16] >= 6'd8 && ch < NCH) begin
        case (f[23:22])
          2'd3: mData[ch] = f[15:0];
          2'd2: mOfs[ch]  = f[15:0];
          default: mGain[ch] = f[15:0];
        endcase
      end
    end else begin
      if (f[21:16] == 6'd1) mCtrl = f[15:0];
      else if (f[21:16] >= 6'd2 && f[21:16] <= 6'd4) mGofs[int'(f[21:16]) - 2] = f[13:0];
    end
  endfunction

  function automatic logic [NCH*16-1:0] expCodes(input bit narrow);
    logic [NCH*16-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*16 +: 16] = narrow ? (mData[i] & 16'hFFFC) : mData[i];
    return v;
  endfunction

  function automatic logic [NCH*14-1:0] expGofs();
    logic [NCH*14-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*14 +: 14] = mGofs[(i / 4) > 2 ? 2 : (i / 4)];
    return v;
  endfunction

  task automatic xfer(input logic [31:0] word, input int nbits,
                      output logic [23:0] rx, output logic [23:0] rx14);
    rx = '0; rx14 = '0;
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = word[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[22:0], miso};
      rx14 = {rx14[22:0], miso14};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] f, output logic [23:0] rx, output logic [23:0] rx14);
    xfer({8'd0, f}, 24, rx, rx14);
    if (!(f[23:22] == 2'd0 && f[21:16] == 6'd5)) applyModel(f);
  endtask

  function automatic logic [23:0] randWrite();
    logic [1:0] c;
    logic [5:0] a;
    c = 2'($urandom_range(0, 3));
    if (c == 2'd0) begin
      a = 6'($urandom_range(0, 6));
      if (a == 6'd5) a = 6'd0;
    end else begin
      a = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(0, 63)) : 6'($urandom_range(8, 8 + NCH - 1));
    end
    return mk(c, a, 16'($urandom));
  endfunction

  initial begin
    logic [23:0] r, r14, fA, fC;
    logic [2:0] t;
    logic [5:0] a;
    logic [15:0] e, e14;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NCH; i++) begin mData[i] = 0; mOfs[i] = 0; mGain[i] = 16'hFFFF; end
    mCtrl = 0;
    for (int k = 0; k < 3; k++) mGofs[k] = 0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 codes reset", codes, '0);
    check("R9 powerDown reset", pd, 1'b0);
    check("R9 groupOfs reset", gofs, '0);
    check("R11 miso idle", miso, 1'b0);
    send(rbReq(3'd3, 6'd8), r, r14);
    check("R9 first frame returns zero", r, 24'd0);
    send(mk(2'd0, 6'd0, 16'd0), r, r14);
    check("R9 gain reset 0xFFFF", r, 24'h00FFFF);
    check("R12 gain reset 0xFFFC", r14, 24'h00FFFC);

    // R1 and R12 data write
    send(mk(2'd3, 6'd9, 16'hABCF), r, r14);
    check("R1 data on port ch1", codes[16 +: 16], 16'hABCF);
    check("R12 narrow data ch1", codes14[16 +: 16], 16'hABCC);
    check("R11 follow non-readback zero", r, 24'd0);

    // R3 out-of-range writes ignored
    send(mk(2'd3, 6'd7, 16'h1234), r, r14);
    send(mk(2'd3, 6'(8 + NCH), 16'h5678), r, r14);
    check("R3 out-of-range ignored", codes, expCodes(0));
    // R6 readback beyond channel count
    send(rbReq(3'd0, 6'(8 + NCH)), r, r14);
    send(mk(2'd0, 6'd0, 16'd0), r, r14);
    check("R6 invalid channel reads zero", r, 24'd0);

    // R7 power down
    send(mk(2'd0, 6'd1, 16'h0003), r, r14);
    check("R7 powerDown set", pd, 1'b1);
    send(mk(2'd3, 6'd8, 16'h0001), r, r14);
    check("R7 powerDown held on data write", pd, 1'b1);
    send(mk(2'd0, 6'd1, 16'h0002), r, r14);
    check("R7 powerDown cleared", pd, 1'b0);

    // R8 group offsets with clamp
    send(mk(2'd0, 6'd4, 16'hFFFF), r, r14);
    send(mk(2'd0, 6'd2, 16'h1234), r, r14);
    check("R8 ch15 uses group offset 2", gofs[15*14 +: 14], 14'h3FFF);
    check("R8 ch0 uses group offset 0", gofs[0 +: 14], 14'h1234);
    check("R8 all channels", gofs, expGofs());
    send(rbReq(3'd4, 6'd4), r, r14);
    send(mk(2'd0, 6'd0, 16'd0), r, r14);
    check("R5 special readback gofs2", r, 24'h003FFF);

    // R10 bad-length frames
    xfer({8'd0, mk(2'd3, 6'd10, 16'h7777)} >> 1, 23, r, r14);
    xfer({mk(2'd3, 6'd10, 16'h7777), 1'b1}, 25, r, r14);
    check("R10 short/long frames discarded", codes, expCodes(0));
    xfer({8'd0, rbReq(3'd4, 6'd1)} >> 1, 23, r, r14);
    send(mk(2'd0, 6'd0, 16'd0), r, r14);
    check("R10 short readback request returns zero", r, 24'd0);

    // R5 type 5-7 and special addr 0
    send(rbReq(3'd6, 6'd8), r, r14);
    send(rbReq(3'd4, 6'd0), r, r14);
    check("R5 type 6 reads zero", r, 24'd0);
    send(mk(2'd0, 6'd0, 16'd0), r, r14);
    check("R5 special addr 0 reads zero", r, 24'd0);

    // Random rounds: R1 R2 R4 R5 collision of readback and write
    for (int it = 0; it < 90; it++) begin
      fA = randWrite();
      send(fA, r, r14);
      t = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) t = 3'($urandom_range(0, 4));
      a = (t == 3'd4) ? 6'($urandom_range(0, 7)) : 6'($urandom_range(6, 8 + NCH + 1));
      send(rbReq(t, a), r, r14);
      check("R11 return after write frame", r, 24'd0);
      e = expRead(t, a, 0);
      e14 = expRead(t, a, 1);
      fC = randWrite();
      if ($urandom_range(0, 1) == 1 && t <= 3'd3 && t != 3'd1) fC = mk(2'(t == 3'd0 ? 3 : (t == 3'd2 ? 2 : 1)), a, 16'($urandom));
      send(fC, r, r14);
      check("R4 R5 readback value", r, {8'd0, e});
      check("R12 narrow readback value", r14, {8'd0, e14});
      check("R1 R2 codes after write", codes, expCodes(0));
      check("R8 groupOfs after write", gofs, expGofs());
      check("R7 powerDown matches ctrl", pd, mCtrl[0]);
    end

    // R2 explicit offset and gain readback
    send(mk(2'd2, 6'd12, 16'h0F0F), r, r14);
    send(mk(2'd1, 6'd12, 16'h8001), r, r14);
    send(rbReq(3'd2, 6'd12), r, r14);
    send(rbReq(3'd3, 6'd12), r, r14);
    check("R2 offset readback", r, 24'h000F0F);
    send(mk(2'd0, 6'd0, 16'd0), r, r14);
    check("R2 gain readback", r, 24'h008001);
    check("R12 narrow gain readback", r14, 24'h008000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule